// File: doc/BRIEF.md
# Two-Wire Bus EEPROM Slave

This block models a 256-byte electrically erasable memory that answers as a slave on a two-wire serial bus. A fast system clock oversamples the clock line and the data line. The block finds bus Start and Stop events, shifts in an address byte, and answers only when that byte carries its device code and the level of its three chip-select pins. It drives the data line only through a pull-low enable, and it never drives the line high, so the pin can be wired open-drain.

A write names a word address and then sends data bytes. These bytes are collected in a 16-entry page buffer, indexed by the low four address bits. The collected bytes are copied into the array by a timed programming cycle that starts at the closing Stop. While that cycle runs, the slave acknowledges nothing. A read returns bytes from the current address pointer, most significant bit first, until the master withholds its acknowledge. A random read is a write of only the word address, followed by a repeated Start with the read bit set. A write-lock input keeps the whole array unchanged.

Top module: `twowire_eeprom`

## Requirements
- R1: A Start (data line falls while the clock line is high) begins address reception from any state. A Stop (data line rises while the clock line is high) returns the slave to idle. The pull-low output changes only in the cycle after a detected clock fall, Start or Stop, so it moves only while the clock line is low.
- R2: The slave acknowledges an address byte only when bits 7..4 equal 1010 and bits 3..1 equal the chip-select pins, received most significant bit first. Bit 0 set to 1 means read. Any other address byte gets no acknowledge, and the slave stays silent until the next Start.
- R3: After each byte it accepts, the slave pulls the data line low from the eighth clock fall to the ninth clock fall, so the line stays low for the whole ninth high period.
- R4: In a write, the first byte after the address becomes the word address. Each following data byte is placed at the current address, and then only the low four address bits advance, wrapping inside the 16-byte page.
- R5: When more than sixteen data bytes arrive, each byte replaces the one sent sixteen bytes earlier, so the last sixteen bytes are kept.
- R6: After a Stop that ends a write of at least one data byte, the buffered bytes are committed to the array after PROG_CYCLES clocks. Until then, no address byte is acknowledged.
- R7: If the write-lock input is high at the closing Stop, no array location changes and no programming cycle starts.
- R8: A read returns the byte at the current pointer, most significant bit first. The pointer then advances over all eight bits and wraps from 255 to 0. A word-address write followed by a repeated Start sets where the read begins.
- R9: When the master leaves the acknowledge bit high after a read byte, the slave releases the data line and stays released until the next Start or Stop.
- R10: A Stop that arrives after two or more bits of a data byte, or a Start that arrives during a write, discards the write. No location changes and no programming cycle starts.
- R11: After reset the data line is released, the pointer is 0 and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired, includes own pull) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| chip_sel_i | input | 3 | Chip-select level compared with address bits 3..1 |
| wr_lock_i | input | 1 | 1 blocks all array changes |

## Verification
A wrong bit counter or wrong state shows up at the ports within one byte time. The acknowledge lands on the wrong clock, or the slave keeps pulling the line after a withheld acknowledge. Address pointer errors show up only on the next read, as a byte taken from the wrong location. Errors in the buffer or in the commit show up after the programming cycle, when a read returns stale or misplaced data. The busy window is observed by polling with address bytes and counting how long acknowledges are withheld.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tw_state_e;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_cur, sda_cur;

    assign scl_cur = smp_q.scl_sync[SYNC_STAGES-1];
    assign sda_cur = smp_q.sda_sync[SYNC_STAGES-1];

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[SYNC_STAGES-2:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[SYNC_STAGES-2:0], sda_i};
        smp_d.scl_prev = scl_cur;
        smp_d.sda_prev = sda_cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    // Bus idles high, so the reset value of all ones produces no false event.
    assign sda_lvl_o  = sda_cur;
    assign scl_rise_o = scl_cur & ~smp_q.scl_prev;
    assign scl_fall_o = ~scl_cur & smp_q.scl_prev;
    assign start_o    = scl_cur & smp_q.scl_prev & smp_q.sda_prev & ~sda_cur;
    assign stop_o     = scl_cur & smp_q.scl_prev & ~smp_q.sda_prev & sda_cur;

endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CNT_W'(1));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R6
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

endmodule

// File: rtl/tw_page_buffer.sv
module tw_page_buffer
    import tw_eeprom_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr_i,
    input  logic                             wr_i,
    input  logic [PAGE_W-1:0]                off_i,
    input  logic [BYTE_W-1:0]                data_i,
    output logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] data_o,
    output logic [(1<<PAGE_W)-1:0]           valid_o
);

    localparam int PAGE_LEN = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGE_LEN-1:0][BYTE_W-1:0] data;
        logic [PAGE_LEN-1:0]             valid;
    } pbuf_t;

    pbuf_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clr_i) pb_d.valid = '0;
        if (wr_i) begin
            pb_d.data[off_i]  = data_i;
            pb_d.valid[off_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign data_o  = pb_q.data;
    assign valid_o = pb_q.valid;

    // R5
    valid_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ($countones(valid_o) >= $countones($past(valid_o))));

endmodule

// File: rtl/tw_cell_array.sv
module tw_cell_array
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]           page_i,
    input  logic [(1<<PAGE_W)-1:0][BYTE_W-1:0] buf_i,
    input  logic [(1<<PAGE_W)-1:0]             valid_i,
    input  logic [ADDR_W-1:0]                  raddr_i,
    output logic [BYTE_W-1:0]                  rdata_o
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAGE_LEN = 1 << PAGE_W;

    logic [BYTE_W-1:0] mem_d [DEPTH];
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int o = 0; o < PAGE_LEN; o++) begin
                if (valid_i[o]) mem_d[{page_i, PAGE_W'(o)}] = buf_i[o];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < DEPTH; p++) mem_q[p] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // R6
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> !commit_i);

endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int PROG_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [2:0] chip_sel_i,
    input  logic       wr_lock_i
);

    localparam int PAGE_LEN = 1 << PAGE_W;

    typedef struct packed {
        tw_state_e         state;
        tw_state_e         ack_next;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [ADDR_W-1:0] addr;
        logic              pull;
        logic              mack;
        logic              pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic prog_start, prog_busy, prog_done;
    logic buf_clr, buf_wr;
    logic dev_hit;
    logic [BYTE_W-1:0] rdata;
    logic [PAGE_LEN-1:0][BYTE_W-1:0] buf_data;
    logic [PAGE_LEN-1:0] buf_valid;

    tw_line_sampler #(.SYNC_STAGES(2)) i_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    tw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (prog_busy),
        .done_o  (prog_done)
    );

    tw_page_buffer #(.PAGE_W(PAGE_W)) i_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .wr_i    (buf_wr),
        .off_i   (ctl_q.addr[PAGE_W-1:0]),
        .data_i  (ctl_q.shreg),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    tw_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (prog_done),
        .page_i   (ctl_q.addr[ADDR_W-1:PAGE_W]),
        .buf_i    (buf_data),
        .valid_i  (buf_valid),
        .raddr_i  (ctl_q.addr),
        .rdata_o  (rdata)
    );

    assign dev_hit = (ctl_q.shreg[7:4] == DEV_CODE) &&
                     (ctl_q.shreg[3:1] == chip_sel_i) && !prog_busy;

    always_comb begin
        ctl_d      = ctl_q;
        buf_clr    = 1'b0;
        buf_wr     = 1'b0;
        prog_start = 1'b0;
        if (bus_start) begin
            ctl_d.state  = ST_DEV;
            ctl_d.bitcnt = '0;
            ctl_d.pull   = 1'b0;
            ctl_d.pend   = 1'b0;
        end else if (bus_stop) begin
            if (ctl_q.pend && ctl_q.state == ST_WDATA &&
                ctl_q.bitcnt <= 4'd1 && !wr_lock_i)
                prog_start = 1'b1;
            ctl_d.state  = ST_IDLE;
            ctl_d.bitcnt = '0;
            ctl_d.pull   = 1'b0;
            ctl_d.pend   = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        ctl_d.shreg  = {ctl_q.shreg[BYTE_W-2:0], sda_lvl};
                        ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                    end else if (scl_fall && ctl_q.bitcnt == 4'd8) begin
                        ctl_d.state    = ST_ACK;
                        ctl_d.pull     = 1'b1;
                        ctl_d.ack_next = ST_WDATA;
                        if (ctl_q.state == ST_DEV) begin
                            if (dev_hit) begin
                                ctl_d.ack_next = ctl_q.shreg[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                ctl_d.state = ST_SKIP;
                                ctl_d.pull  = 1'b0;
                            end
                        end else if (ctl_q.state == ST_WADDR) begin
                            ctl_d.addr = ctl_q.shreg;
                            buf_clr    = 1'b1;
                        end else begin
                            buf_wr     = 1'b1;
                            ctl_d.pend = 1'b1;
                            ctl_d.addr = {ctl_q.addr[ADDR_W-1:PAGE_W],
                                          ctl_q.addr[PAGE_W-1:0] + PAGE_W'(1)};
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctl_d.state  = ctl_q.ack_next;
                        ctl_d.bitcnt = '0;
                        ctl_d.pull   = 1'b0;
                        if (ctl_q.ack_next == ST_RDATA) begin
                            ctl_d.shreg = rdata;
                            ctl_d.pull  = ~rdata[BYTE_W-1];
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (ctl_q.bitcnt == 4'd7) begin
                            ctl_d.pull  = 1'b0;
                            ctl_d.state = ST_RACK;
                            ctl_d.addr  = ctl_q.addr + ADDR_W'(1);
                        end else begin
                            ctl_d.bitcnt = ctl_q.bitcnt + 4'd1;
                            ctl_d.shreg  = {ctl_q.shreg[BYTE_W-2:0], 1'b0};
                            ctl_d.pull   = ~ctl_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ctl_d.mack = sda_lvl;
                    end else if (scl_fall) begin
                        if (!ctl_q.mack) begin
                            ctl_d.state  = ST_RDATA;
                            ctl_d.bitcnt = '0;
                            ctl_d.shreg  = rdata;
                            ctl_d.pull   = ~rdata[BYTE_W-1];
                        end else begin
                            ctl_d.state = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.state    <= ST_IDLE;
            ctl_q.ack_next <= ST_IDLE;
            ctl_q.mack     <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull_o = ctl_q.pull;

    // R1
    pull_move_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.pull != $past(ctl_q.pull)) |-> $past(scl_fall || bus_start || bus_stop));

    // R6
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> (ctl_q.state != ST_ACK));

    // R7
    lock_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !wr_lock_i);

    // R9
    skip_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SKIP) |-> !sda_pull_o);

endmodule

// File: tb/test_twowire_eeprom.sv
module test_twowire_eeprom;

    localparam int PROG = 200;
    localparam logic [2:0] MY_CS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] cs = MY_CS;
    logic lock = 1'b0;
    logic pull;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~pull;

    twowire_eeprom #(.PROG_CYCLES(PROG)) i_twowire_eeprom (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .chip_sel_i (cs),
        .wr_lock_i  (lock)
    );

    function automatic logic [7:0] dev_byte(input logic [2:0] sel, input logic rd);
        return {4'b1010, sel, rd};
    endfunction

    function automatic logic [7:0] page_addr(input logic [7:0] base, input int i);
        return {base[7:4], 4'(int'(base[3:0]) + i)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(4);
        scl = 1'b1;   wait_cyc(8);
        sda_m = 1'b0; wait_cyc(8);
        scl = 1'b0;   wait_cyc(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(4);
        scl = 1'b1;   wait_cyc(8);
        sda_m = 1'b1; wait_cyc(8);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b; wait_cyc(4);
        scl = 1'b1; wait_cyc(4);
        seen = sda_line;
        wait_cyc(4);
        scl = 1'b0; wait_cyc(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    task automatic wait_ready(input string req);
        logic a;
        logic got = 1'b0;
        int polls = 0;
        for (int t = 0; t < 40 && !got; t++) begin
            bus_start();
            send_byte(dev_byte(MY_CS, 1'b0), a);
            bus_stop();
            if (t == 0) chk({req, " address refused while programming"}, a, 1'b0);
            got = a;
            polls++;
        end
        chk({req, " programming ends"}, got, 1'b1);
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input logic locked);
        logic ack;
        logic [7:0] d;
        lock = locked;
        bus_start();
        send_byte(dev_byte(MY_CS, 1'b0), ack);
        chk("R2 write address ack", ack, 1'b1);
        send_byte(a, ack);
        chk("R3 word address ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            if (i == 0 || i == n - 1) chk("R3 data ack", ack, 1'b1);
            if (!locked) exp_mem[page_addr(a, i)] = d;   // R4 R5
        end
        bus_stop();
        lock = 1'b0;
        exp_ptr = page_addr(a, n);
        if (locked) begin
            bus_start();
            send_byte(dev_byte(MY_CS, 1'b0), ack);
            bus_stop();
            chk("R7 no programming cycle when locked", ack, 1'b1);
        end else begin
            wait_ready("R6");
        end
    endtask

    task automatic do_read(input logic set_addr, input logic [7:0] a, input int n);
        logic ack;
        logic [7:0] d;
        bus_start();
        if (set_addr) begin
            send_byte(dev_byte(MY_CS, 1'b0), ack);
            send_byte(a, ack);
            exp_ptr = a;
            bus_start();
        end
        send_byte(dev_byte(MY_CS, 1'b1), ack);
        chk("R2 read address ack", ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk("R8 read data", d, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        wait_cyc(2);
        chk("R9 line released after master nack", pull, 1'b0);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [2:0] bad;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        wait_cyc(5);
        chk("R11 released in reset", pull, 1'b0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R11 released after reset", pull, 1'b0);

        // R11: pointer 0, cleared array
        do_read(1'b0, 8'h00, 2);

        // R5: twenty bytes into one page
        do_write(8'h35, 20, 1'b0);
        do_read(1'b1, 8'h30, 16);

        // R8: pointer wraps past 255
        do_write(8'hFE, 2, 1'b0);
        do_read(1'b1, 8'hFF, 3);

        // R10: Stop in the middle of a data byte
        bus_start();
        send_byte(dev_byte(MY_CS, 1'b0), ack);
        send_byte(8'h40, ack);
        send_byte(8'hA5, ack);
        send_byte(8'h5A, ack);
        for (int i = 0; i < 3; i++) clock_bit(1'b1, d[0]);
        bus_stop();
        exp_ptr = page_addr(8'h40, 2);
        bus_start();
        send_byte(dev_byte(MY_CS, 1'b0), ack);
        bus_stop();
        chk("R10 no programming after abort", ack, 1'b1);
        do_read(1'b1, 8'h40, 2);

        // R7: locked write over written data
        do_write(8'h36, 4, 1'b1);
        do_read(1'b1, 8'h36, 4);

        for (int it = 0; it < 24; it++) begin
            int kind = int'($urandom % 5);
            case (kind)
                0: do_write(8'($urandom), 1 + int'($urandom % 20), 1'b0);
                1: do_write(8'($urandom), 1 + int'($urandom % 6), 1'b1);
                2: do_read(1'b1, 8'($urandom), 1 + int'($urandom % 6));
                3: do_read(1'b0, 8'h00, 1 + int'($urandom % 4));
                default: begin
                    bad = MY_CS ^ 3'(1 + ($urandom % 7));
                    bus_start();
                    send_byte(dev_byte(bad, 1'($urandom)), ack);
                    chk("R2 other chip select refused", ack, 1'b0);
                    send_byte(8'h00, ack);
                    chk("R2 silent until next start", ack, 1'b0);
                    bus_stop();
                    bus_start();
                    send_byte({4'b1011, MY_CS, 1'b1}, ack);
                    chk("R2 wrong device code refused", ack, 1'b0);
                    bus_stop();
                end
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule